// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block walks through the elements of one vector load instruction and produces one memory read per active element. For every element it reads a base value through a register-file read port and adds an offset that depends on the addressing mode. The memory request uses a valid/ready handshake and the block waits for the single outstanding response. The returned data goes out on a register-file write port, at the destination index plus the destination element number. When the instruction asks for base update, the computed address is also written back through a second write port.

There are four addressing modes. A vector source gives indirect (gather) addressing. A scalar source gives element-stride, unit-stride or splat addressing. Destination elements whose predicate bit is clear are skipped. A scalar destination ends the sequence after exactly one load. The block takes a new instruction only while idle, keeps `busy` high for the whole sequence, and pulses `done` once on its last cycle.

Top module: `vload_agen`

## Requirements
- R1: The access width code sets the unit-stride step in bytes: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R2: When `srcIsVec` is 1, the address of each element is the register at `srcIdx + i` plus the sign-extended immediate, whatever `ldMode` holds. Here `i` is the source element counter.
- R3: When the source is scalar and `ldMode` is 2'b01 (element stride), the address is the register at `srcIdx` plus `j` times the sign-extended immediate. Here `j` is the destination element number.
- R4: When the source is scalar and `ldMode` is 2'b10 (unit stride), the address is the register at `srcIdx` plus `j` times the R1 byte count.
- R5: When the source is scalar and `ldMode` is 2'b00 or 2'b11 (splat), the address is the register at `srcIdx` plus the sign-extended immediate for every element.
- R6: When `dstIsVec` is 1, each element `j` whose `predMask[j]` is 0 is skipped: it causes no memory request and no register write. With a scalar destination the predicate is ignored.
- R7: Elements are processed while both `i` and `j` are below the vector length. A `vecLen` above 64 counts as 64. After each load, `i` advances only for a vector source and `j` only for a vector destination.
- R8: With a scalar destination, the sequence ends after the first load. Data is written at `dstIdx`.
- R9: With `update` set, each memory request handshake writes the request address to register `srcIdx + i` on the update port, in the same cycle. Later elements read the updated value.
- R10: `done` is high for exactly one cycle at the end of each sequence. A zero vector length, or a vector destination with no set predicate bits, ends with zero loads.
- R11: `busy` is high from the cycle after `start` is accepted through the `done` cycle, and is low otherwise. A `start` while busy is ignored.
- R12: A memory request holds `memReqValid` and a stable `memReqAddr` until `memReqReady`. Address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new instruction when idle |
| vecLen | input | 7 | Vector length, 0 to 64 |
| predMask | input | 64 | Destination predicate, bit j for element j |
| srcIsVec | input | 1 | Source register is a vector |
| dstIsVec | input | 1 | Destination register is a vector |
| ldMode | input | 2 | 00/11 splat, 01 element stride, 10 unit stride |
| widthCode | input | 2 | Access width code (R1) |
| immed | input | 16 | Signed immediate |
| update | input | 1 | Write computed addresses back to the source registers |
| srcIdx | input | 7 | Source register index |
| dstIdx | input | 7 | Destination register index |
| rfRdIdx | output | 7 | Register read index for the base value |
| rfRdData | input | 64 | Register read data, same cycle |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory read request ready |
| memReqAddr | output | 64 | Memory read address |
| memRspValid | input | 1 | Memory response valid |
| memRspData | input | 64 | Memory response data |
| rfWrEn | output | 1 | Destination write enable |
| rfWrIdx | output | 7 | Destination write index |
| rfWrData | output | 64 | Destination write data |
| upWrEn | output | 1 | Update write enable |
| upWrIdx | output | 7 | Update write index |
| upWrData | output | 64 | Update write data (the address) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |

## Verification
The bench targets splat runs with update, where each element has to read the value the previous element wrote back. A design that latched the base once would repeat one address instead of stepping it. It drives sparse and all-zero predicates. A sequencer that issued masked elements would emit extra requests, and one that miscounted skips would write the wrong destination index. A scalar destination with a zero predicate must still load once, and a wrong design would load nothing. A base near 2^64 - 1 with a positive immediate must give a wrapped address. The bench also withholds ready and raises `start` mid-run: the request address must hold, and the running instruction must not change.

// File: rtl/vload_agen_pkg.sv
package vload_agen_pkg;

  localparam logic [1:0] MODE_SPLAT   = 2'b00;
  localparam logic [1:0] MODE_ESTRIDE = 2'b01;
  localparam logic [1:0] MODE_USTRIDE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch a new instruction, clear counters
    logic skipDst;    // step j past a masked element
    logic latchAddr;  // register the computed address
    logic advance;    // step counters after a completed load
  } seqStrobe_t;

endpackage

// File: rtl/vload_agen_dpath.sv
module vload_agen_dpath
  import vload_agen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MAXVL = 64,
  parameter int IMM_W = 16,
  parameter int REG_W = 7,
  localparam int VL_W = $clog2(MAXVL + 1),
  localparam int PI_W = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       stb,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [MAXVL-1:0] predMask,
  input  logic             srcIsVec,
  input  logic             dstIsVec,
  input  logic [1:0]       ldMode,
  input  logic [1:0]       widthCode,
  input  logic [IMM_W-1:0] immed,
  input  logic             update,
  input  logic [REG_W-1:0] srcIdx,
  input  logic [REG_W-1:0] dstIdx,
  output logic [REG_W-1:0] rfRdIdx,
  input  logic [XLEN-1:0]  rfRdData,
  input  logic [XLEN-1:0]  memRspData,
  output logic             seqEnd,
  output logic             predOff,
  output logic             dstScalar,
  output logic             updFlag,
  output logic [XLEN-1:0]  memReqAddr,
  output logic [REG_W-1:0] rfWrIdx,
  output logic [XLEN-1:0]  rfWrData,
  output logic [REG_W-1:0] upWrIdx,
  output logic [XLEN-1:0]  upWrData
);

  logic [VL_W-1:0]  vlR;
  logic [MAXVL-1:0] predR;
  logic             srcVecR, dstVecR, updR;
  logic [1:0]       modeR, widthR;
  logic [IMM_W-1:0] immR;
  logic [REG_W-1:0] srcR, dstR;
  logic [VL_W-1:0]  iCnt, jCnt;
  logic [XLEN-1:0]  eaR;

  logic [XLEN-1:0]  immX;
  logic [XLEN-1:0]  stepBytes;
  logic [XLEN-1:0]  offs;
  logic [XLEN-1:0]  eaNext;
  logic [VL_W-1:0]  vlClamp;

  assign vlClamp = (vecLen > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vecLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vlR     <= '0;
      predR   <= '0;
      srcVecR <= 1'b0;
      dstVecR <= 1'b0;
      updR    <= 1'b0;
      modeR   <= MODE_SPLAT;
      widthR  <= '0;
      immR    <= '0;
      srcR    <= '0;
      dstR    <= '0;
      iCnt    <= '0;
      jCnt    <= '0;
      eaR     <= '0;
    end else begin
      if (stb.capture) begin
        vlR     <= vlClamp;
        predR   <= predMask;
        srcVecR <= srcIsVec;
        dstVecR <= dstIsVec;
        updR    <= update;
        modeR   <= ldMode;
        widthR  <= widthCode;
        immR    <= immed;
        srcR    <= srcIdx;
        dstR    <= dstIdx;
        iCnt    <= '0;
        jCnt    <= '0;
      end
      if (stb.skipDst) jCnt <= jCnt + 1'b1;
      if (stb.advance) begin
        if (srcVecR) iCnt <= iCnt + 1'b1;
        if (dstVecR) jCnt <= jCnt + 1'b1;
      end
      if (stb.latchAddr) eaR <= eaNext;
    end
  end

  // sign extension of the immediate
  assign immX = {{(XLEN-IMM_W){immR[IMM_W-1]}}, immR};

  // R1: width code to byte step
  assign stepBytes = XLEN'(1) << widthR;

  // offset selection: vector source is indirect, otherwise by mode
  always_comb begin
    if (srcVecR) begin
      offs = immX;
    end else begin
      case (modeR)
        MODE_ESTRIDE: offs = XLEN'(jCnt) * immX;
        MODE_USTRIDE: offs = XLEN'(jCnt) * stepBytes;
        default:      offs = immX;
      endcase
    end
  end

  assign rfRdIdx = srcVecR ? (srcR + REG_W'(iCnt)) : srcR;
  assign eaNext  = rfRdData + offs;

  assign seqEnd    = (iCnt >= vlR) || (jCnt >= vlR);
  assign predOff   = dstVecR && !predR[jCnt[PI_W-1:0]];
  assign dstScalar = !dstVecR;
  assign updFlag   = updR;

  assign memReqAddr = eaR;
  assign upWrIdx    = srcR + REG_W'(iCnt);
  assign upWrData   = eaR;
  assign rfWrIdx    = dstR + REG_W'(jCnt);
  assign rfWrData   = memRspData;

  // R7
  counter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iCnt <= VL_W'(MAXVL)) && (jCnt <= VL_W'(MAXVL)));

  // R8
  scalar_dst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.advance |-> dstVecR);

  // R7
  no_issue_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.latchAddr |-> (iCnt < vlR) && (jCnt < vlR));

endmodule

// File: rtl/vload_agen_ctrl.sv
module vload_agen_ctrl
  import vload_agen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       seqEnd,
  input  logic       predOff,
  input  logic       dstScalar,
  input  logic       updFlag,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output seqStrobe_t stb,
  output logic       memReqValid,
  output logic       rfWrEn,
  output logic       upWrEn,
  output logic       busy,
  output logic       done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    memReqValid = 1'b0;
    rfWrEn      = 1'b0;
    upWrEn      = 1'b0;
    done        = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.capture = 1'b1;
          stateNext   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (seqEnd) begin
          done      = 1'b1;
          stateNext = ST_IDLE;
        end else if (predOff) begin
          stb.skipDst = 1'b1;
        end else begin
          stb.latchAddr = 1'b1;
          stateNext     = ST_REQ;
        end
      end
      ST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          upWrEn    = updFlag;
          stateNext = ST_WAIT;
        end
      end
      default: begin
        if (memRspValid) begin
          rfWrEn = 1'b1;
          if (dstScalar) begin
            done      = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stb.advance = 1'b1;
            stateNext   = ST_SCAN;
          end
        end
      end
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memReqReady |=> memReqValid);

  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R9
  update_on_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upWrEn |-> memReqValid && memReqReady);

  // R6
  write_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfWrEn |-> memRspValid && !memReqValid);

endmodule

// File: rtl/vload_agen.sv
module vload_agen
  import vload_agen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MAXVL = 64,
  parameter int IMM_W = 16,
  parameter int REG_W = 7,
  localparam int VL_W = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [MAXVL-1:0] predMask,
  input  logic             srcIsVec,
  input  logic             dstIsVec,
  input  logic [1:0]       ldMode,
  input  logic [1:0]       widthCode,
  input  logic [IMM_W-1:0] immed,
  input  logic             update,
  input  logic [REG_W-1:0] srcIdx,
  input  logic [REG_W-1:0] dstIdx,
  output logic [REG_W-1:0] rfRdIdx,
  input  logic [XLEN-1:0]  rfRdData,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [XLEN-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [XLEN-1:0]  memRspData,
  output logic             rfWrEn,
  output logic [REG_W-1:0] rfWrIdx,
  output logic [XLEN-1:0]  rfWrData,
  output logic             upWrEn,
  output logic [REG_W-1:0] upWrIdx,
  output logic [XLEN-1:0]  upWrData,
  output logic             busy,
  output logic             done
);

  seqStrobe_t stb;
  logic seqEnd, predOff, dstScalar, updFlag;

  vload_agen_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .seqEnd      (seqEnd),
    .predOff     (predOff),
    .dstScalar   (dstScalar),
    .updFlag     (updFlag),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .stb         (stb),
    .memReqValid (memReqValid),
    .rfWrEn      (rfWrEn),
    .upWrEn      (upWrEn),
    .busy        (busy),
    .done        (done)
  );

  vload_agen_dpath #(
    .XLEN  (XLEN),
    .MAXVL (MAXVL),
    .IMM_W (IMM_W),
    .REG_W (REG_W)
  ) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .vecLen     (vecLen),
    .predMask   (predMask),
    .srcIsVec   (srcIsVec),
    .dstIsVec   (dstIsVec),
    .ldMode     (ldMode),
    .widthCode  (widthCode),
    .immed      (immed),
    .update     (update),
    .srcIdx     (srcIdx),
    .dstIdx     (dstIdx),
    .rfRdIdx    (rfRdIdx),
    .rfRdData   (rfRdData),
    .memRspData (memRspData),
    .seqEnd     (seqEnd),
    .predOff    (predOff),
    .dstScalar  (dstScalar),
    .updFlag    (updFlag),
    .memReqAddr (memReqAddr),
    .rfWrIdx    (rfWrIdx),
    .rfWrData   (rfWrData),
    .upWrIdx    (upWrIdx),
    .upWrData   (upWrData)
  );

  // R12
  req_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

endmodule

// File: tb/vload_agen_tb_top.sv
`timescale 1ns/1ps
module vload_agen_tb_top;
  localparam int XLEN = 64, MAXVL = 64, IMM_W = 16, REG_W = 7, VL_W = 7, NREG = 128;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start;
  logic [VL_W-1:0] vecLen;
  logic [MAXVL-1:0] predMask;
  logic srcIsVec, dstIsVec, update;
  logic [1:0] ldMode, widthCode;
  logic [IMM_W-1:0] immed;
  logic [REG_W-1:0] srcIdx, dstIdx, rfRdIdx, rfWrIdx, upWrIdx;
  logic [XLEN-1:0] rfRdData, memReqAddr, memRspData, rfWrData, upWrData;
  logic memReqValid, memReqReady, memRspValid, rfWrEn, upWrEn, busy, done;

  vload_agen dut_i (.*);

  // bench register file
  logic [XLEN-1:0] rf [NREG];
  logic pokeEn;
  logic [REG_W-1:0] pokeIdx;
  logic [XLEN-1:0] pokeVal;
  assign rfRdData = rf[rfRdIdx];

  function automatic logic [XLEN-1:0] initVal(int k);
    return XLEN'(k) * 64'h9E37_79B9_7F4A_7C15 + 64'h0000_1000_0000_0040;
  endfunction

  function automatic logic [XLEN-1:0] memFn(logic [XLEN-1:0] a);
    return {a[31:0], a[63:32]} ^ 64'hA5A5_0F0F_1234_5678;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) rf[k] <= initVal(k);
    end else begin
      if (pokeEn) rf[pokeIdx] <= pokeVal;
      if (upWrEn) rf[upWrIdx] <= upWrData;
      if (rfWrEn) rf[rfWrIdx] <= rfWrData;
    end
  end

  // memory: random ready, one response after 1..3 cycles
  logic slowReady;
  logic pend;
  logic [1:0] rspDly;
  logic [XLEN-1:0] rspAddr;
  always @(posedge clk) begin
    if (!rst_n) begin
      memReqReady <= 1'b0; memRspValid <= 1'b0; memRspData <= '0;
      pend <= 1'b0; rspDly <= '0; rspAddr <= '0;
    end else begin
      memReqReady <= slowReady ? ($urandom % 4 == 0) : ($urandom % 3 != 0);
      if (memRspValid) memRspValid <= 1'b0;
      if (memReqValid && memReqReady) begin
        pend <= 1'b1; rspDly <= 2'($urandom % 3); rspAddr <= memReqAddr;
      end else if (pend) begin
        if (rspDly == 0) begin
          memRspValid <= 1'b1; memRspData <= memFn(rspAddr); pend <= 1'b0;
        end else rspDly <= rspDly - 1'b1;
      end
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model
  logic [XLEN-1:0] mrf [NREG];
  logic [XLEN-1:0] expAddr [MAXVL];
  logic [REG_W-1:0] expUpIdx [MAXVL];
  logic [REG_W-1:0] expDIdx [MAXVL];
  logic [XLEN-1:0] expDData [MAXVL];
  int expN;

  task automatic model(input int vl, input logic [MAXVL-1:0] pm, input bit sv, input bit dv,
                       input logic [1:0] md, input logic [1:0] wc, input logic [IMM_W-1:0] im,
                       input bit up, input logic [REG_W-1:0] s, input logic [REG_W-1:0] d);
    int i, j, lim;
    logic [XLEN-1:0] base, offs, ea, imx;
    logic [REG_W-1:0] ri;
    lim = (vl > MAXVL) ? MAXVL : vl;
    imx = {{(XLEN-IMM_W){im[IMM_W-1]}}, im};
    i = 0; j = 0; expN = 0;
    while (i < lim && j < lim) begin
      if (dv) begin
        while (j < lim && !pm[j]) j++;
        if (j >= lim) break;
      end
      ri = sv ? REG_W'(s + REG_W'(i)) : s;
      base = mrf[ri];
      if (sv) offs = imx;
      else if (md == 2'b01) offs = XLEN'(j) * imx;
      else if (md == 2'b10) offs = XLEN'(j) * (XLEN'(1) << wc);
      else offs = imx;
      ea = base + offs;
      expAddr[expN] = ea;
      expUpIdx[expN] = REG_W'(s + REG_W'(i));
      if (up) mrf[expUpIdx[expN]] = ea;
      expDIdx[expN] = REG_W'(d + REG_W'(j));
      expDData[expN] = memFn(ea);
      mrf[expDIdx[expN]] = expDData[expN];
      expN++;
      if (!dv) break;
      if (sv) i++;
      if (dv) j++;
    end
  endtask

  task automatic runOne(input int vl, input logic [MAXVL-1:0] pm, input bit sv, input bit dv,
                        input logic [1:0] md, input logic [1:0] wc, input logic [IMM_W-1:0] im,
                        input bit up, input logic [REG_W-1:0] s, input logic [REG_W-1:0] d,
                        input string tag);
    int ai, ui, di, cyc;
    bit fin, busyLost;
    @(negedge clk);
    vecLen = VL_W'(vl); predMask = pm; srcIsVec = sv; dstIsVec = dv; ldMode = md;
    widthCode = wc; immed = im; update = up; srcIdx = s; dstIdx = d;
    for (int k = 0; k < NREG; k++) mrf[k] = rf[k];
    model(vl, pm, sv, dv, md, wc, im, up, s, d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ai = 0; ui = 0; di = 0; cyc = 0; fin = 0; busyLost = 0;
    while (!fin && cyc < 4000) begin
      if (!busy) busyLost = 1;
      if (memReqValid && memReqReady) begin
        if (ai < expN) chk(memReqAddr == expAddr[ai], tag, "request address", memReqAddr, expAddr[ai]);
        else chk(0, tag, "extra request (R6)", memReqAddr, '0);
        ai++;
      end
      if (upWrEn) begin
        if (ui < expN && up)
          chk(upWrIdx == expUpIdx[ui] && upWrData == expAddr[ui], "R9", "update write",
              {upWrIdx, upWrData[56:0]}, {expUpIdx[ui], expAddr[ui][56:0]});
        else chk(0, "R9", "unexpected update write", upWrData, '0);
        ui++;
      end
      if (rfWrEn) begin
        if (di < expN)
          chk(rfWrIdx == expDIdx[di] && rfWrData == expDData[di], "R6", "destination write",
              {rfWrIdx, rfWrData[56:0]}, {expDIdx[di], expDData[di][56:0]});
        else chk(0, "R8", "extra destination write", rfWrData, '0);
        di++;
      end
      if (done) fin = 1;
      // R11: a start while busy must not disturb the running instruction
      if (cyc == 2 && busy && !done) begin
        start = 1'b1; vecLen = 7'd3; srcIsVec = ~sv; dstIsVec = ~dv; immed = 16'h7777;
        srcIdx = 7'd99; dstIdx = 7'd77;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(fin, tag, "sequence finished (watchdog)", XLEN'(fin), 64'd1);
    chk(ai == expN && di == expN, "R10", "load count", XLEN'(ai), XLEN'(expN));
    chk(ui == (up ? expN : 0), "R9", "update count", XLEN'(ui), XLEN'(up ? expN : 0));
    chk(!busyLost, "R11", "busy high during run", XLEN'(busyLost), 64'd0);
    chk(!busy && !done, "R11", "idle after done", {62'd0, busy, done}, 64'd0);
  endtask

  task automatic poke(input logic [REG_W-1:0] idx, input logic [XLEN-1:0] val);
    @(negedge clk);
    pokeEn = 1'b1; pokeIdx = idx; pokeVal = val;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; pokeEn = 1'b0; pokeIdx = '0; pokeVal = '0; slowReady = 1'b0;
    vecLen = '0; predMask = '0; srcIsVec = 0; dstIsVec = 0; ldMode = 0; widthCode = 0;
    immed = '0; update = 0; srcIdx = '0; dstIdx = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReqValid && !rfWrEn && !upWrEn, "R11", "reset state",
        {59'd0, busy, done, memReqValid, rfWrEn, upWrEn}, 64'd0);

    // R1 R4: unit stride with each width, sparse predicate
    for (int w = 0; w < 4; w++)
      runOne(5, 64'b10110, 0, 1, 2'b10, 2'(w), 16'h0, 0, 7'd10, 7'd40, "R4");
    // R3: element stride, negative immediate
    runOne(6, 64'h3F, 0, 1, 2'b01, 2'b00, 16'hFFFD, 0, 7'd11, 7'd50, "R3");
    // R5 R9: splat with update steps the base every element
    runOne(4, 64'hF, 0, 1, 2'b00, 2'b11, 16'h0020, 1, 7'd12, 7'd60, "R5");
    runOne(3, 64'h7, 0, 1, 2'b11, 2'b00, 16'hFFF0, 1, 7'd13, 7'd70, "R5");
    // R2: indirect, vector source and destination, sparse predicate
    runOne(8, 64'b1010_0110, 1, 1, 2'b01, 2'b10, 16'hFFF8, 1, 7'd20, 7'd90, "R2");
    // R8: scalar destination, predicate ignored, single load
    runOne(9, 64'h0, 1, 0, 2'b00, 2'b00, 16'h0004, 0, 7'd21, 7'd5, "R8");
    // R10: zero length and empty predicate
    runOne(0, '1, 1, 1, 2'b00, 2'b00, 16'h0, 0, 7'd0, 7'd1, "R10");
    runOne(10, 64'h0, 0, 1, 2'b10, 2'b11, 16'h0, 0, 7'd2, 7'd3, "R10");
    // R7: full length and clamped length
    runOne(64, '1, 1, 1, 2'b00, 2'b00, 16'h0008, 0, 7'd64, 7'd0, "R7");
    runOne(100, 64'h8000_0000_0000_0001, 0, 1, 2'b10, 2'b01, 16'h0, 0, 7'd3, 7'd4, "R7");
    // R12: wrap and slow ready
    poke(7'd30, 64'hFFFF_FFFF_FFFF_FFF8);
    slowReady = 1'b1;
    runOne(2, 64'h3, 0, 1, 2'b00, 2'b00, 16'h0010, 1, 7'd30, 7'd31, "R12");
    slowReady = 1'b0;

    // constrained random
    for (int n = 0; n < 120; n++) begin
      int vl;
      logic [MAXVL-1:0] pm;
      vl = ($urandom % 8 == 0) ? 64 : int'($urandom % 20);
      pm = {$urandom, $urandom};
      if ($urandom % 4 == 0) pm = pm & {$urandom, $urandom};
      slowReady = ($urandom % 5 == 0);
      runOne(vl, pm, 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
             16'($urandom), 1'($urandom), 7'($urandom), 7'($urandom), "R7");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule